// File: doc/BRIEF.md
# Ordered-Write Symmetric Key Bank

This block holds a 256-bit symmetric key as eight 32-bit words behind a simple register write port. Software loads the key one word per write. The key only counts when the words arrive in strict index order, lowest first. If the order breaks, the key the block presents downstream reads as all zeros until software starts the sequence again from the first word.

The key can also be loaded from a random-number source in a single cycle. The source is modelled as a 256-bit data bus with a valid strobe. A control register picks what the random value does to the stored words: it either overwrites them or is XORed into them. A sticky lock bit in the same register can freeze that choice until the next reset.

The downstream consumer sees the effective key together with a valid flag. While the flag is low, the key bus is forced to zero.

Top module: `ordered_key_bank`

## Requirements
- R1: After reset, `key_valid` is 0 and `key_out` is all zeros. The merge mode is overwrite and the mode lock is clear.
- R2: Key word `i` lives at byte offset `4*i` (offsets 0x00 to 0x1C, with address bits [1:0] ignored). It occupies `key_out[32*i+31:32*i]`. After words 0 through 7 are written in order, `key_valid` is 1 from the cycle after the word-7 write, and `key_out` shows the written words.
- R3: A key-word write whose index is not 0 and not the next expected index makes the sequence broken. From the next cycle `key_valid` is 0. It stays 0 through further key-word writes until a write to word 0.
- R4: A write to word 0 always restarts the sequence. It clears the broken state and drops `key_valid` to 0, and word 1 becomes the expected index.
- R5: Whenever `key_valid` is 0, `key_out` is all zeros. Once a valid key exists, any later key-word write that does not complete an ordered sequence drops `key_valid`.
- R6: When `rng_valid` is 1 and the merge mode is overwrite (mode bit 0), every stored word `i` becomes `rng_data[32*i+31:32*i]` in one cycle. `key_valid` is 1 on the next cycle, and the order tracker restarts, expecting word 0.
- R7: When `rng_valid` is 1 and the merge mode is XOR (mode bit 1), every stored word becomes its previous stored value XOR the matching slice of `rng_data`. This holds even if the previous key was not valid, and `key_valid` becomes 1.
- R8: The control register is at byte offset 0x48. Bit 0 is the merge mode and bit 16 is the mode lock. Writing 1 to bit 16 sets the lock, and the lock then stays 1 until reset. Writing 0 to bit 16 does not clear it.
- R9: While the lock is 1, writes to the mode bit are ignored. A single control write that sets both the lock and a new mode still applies that mode, because the lock acts from the following cycle.
- R10: When `rng_valid` and a key-word write occur in the same cycle, the random load wins and the bus key write is dropped.
- R11: Writes to any other offset (0x20 to 0x47 and 0x49 to 0xFF) change neither the key, the tracker nor the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rng_valid | input | 1 | Random value available; loads the key this cycle |
| rng_data | input | 256 | Random value, word `i` in bits [32i+31:32i] |
| key_out | output | 256 | Effective key, zero while not valid |
| key_valid | output | 1 | Key is complete and usable |

## Verification
The assertions take for granted that `rng_valid` and `wr_en` are synchronous to `clk` and hold known values outside reset. They also assume that a control write is the only thing that moves the mode bit, so a locked mode must stay stable from cycle to cycle.

The stimulus keeps within these limits by driving every input at the falling edge. The random phase mixes mostly in-order key writes with skipped indices, restarts, control writes (which only rarely set the lock), random loads, and writes to unmapped offsets. Directed cases cover the simultaneous random load and key write, and the control write that sets both the mode and the lock. A second reset checks that the lock is released.

// File: rtl/keybank_pkg.sv
package keybank_pkg;
  typedef enum logic {
    MERGE_REPLACE = 1'b0,
    MERGE_XOR     = 1'b1
  } merge_mode_e;

  typedef struct packed {
    logic key_wr;
    logic ctrl_wr;
    logic rng_load;
  } kb_event_t;
endpackage

// File: rtl/kb_order_tracker.sv
module kb_order_tracker #(
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             rng_load,
  output logic [IDX_W-1:0] exp_idx,
  output logic             seq_err,
  output logic             key_valid,
  output logic             seq_restart,
  output logic             seq_match,
  output logic             seq_break,
  output logic             seq_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    seq_restart = key_wr && (wr_idx == '0);
    seq_match   = key_wr && !seq_restart && !seq_err && (wr_idx == exp_idx);
    seq_break   = key_wr && !seq_restart && !seq_match;
    seq_done    = seq_match && (wr_idx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_idx   <= '0;
      seq_err   <= 1'b0;
      key_valid <= 1'b0;
    end else if (rng_load) begin
      exp_idx   <= '0;
      seq_err   <= 1'b0;
      key_valid <= 1'b1;
    end else if (seq_restart) begin
      exp_idx   <= advance('0);
      seq_err   <= 1'b0;
      key_valid <= 1'b0;
    end else if (seq_match) begin
      exp_idx   <= advance(wr_idx);
      key_valid <= seq_done;
    end else if (seq_break) begin
      seq_err   <= 1'b1;
      key_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kb_mode_ctrl.sv
module kb_mode_ctrl
  import keybank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        mode_bit,
  input  logic        lock_bit,
  output merge_mode_e merge_mode,
  output logic        mode_lock
);
  logic mode_accept;

  assign mode_accept = ctrl_wr && !mode_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merge_mode <= MERGE_REPLACE;
      mode_lock  <= 1'b0;
    end else begin
      if (mode_accept) merge_mode <= merge_mode_e'(mode_bit);
      if (ctrl_wr && lock_bit) mode_lock <= 1'b1;
    end
  end
endmodule

// File: rtl/kb_word_store.sv
module kb_word_store
  import keybank_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS),
  parameter int KEY_W     = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rng_load,
  input  merge_mode_e       merge_mode,
  input  logic [KEY_W-1:0]  rng_data,
  output logic [KEY_W-1:0]  key_raw
);
  function automatic logic [WORD_W-1:0] merge_word(
    input merge_mode_e       mode,
    input logic [WORD_W-1:0] prev,
    input logic [WORD_W-1:0] rnd
  );
    return (mode == MERGE_XOR) ? (prev ^ rnd) : rnd;
  endfunction

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;

    assign hit = key_wr && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (rng_load) begin
        word_q <= merge_word(merge_mode, word_q, rng_data[g*WORD_W +: WORD_W]);
      end else if (hit) begin
        word_q <= wr_data;
      end
    end

    assign key_raw[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/ordered_key_bank.sv
module ordered_key_bank
  import keybank_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          NUM_WORDS = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h48,
  parameter int          MODE_POS  = 0,
  parameter int          LOCK_POS  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        rng_valid,
  input  logic [WORD_W*NUM_WORDS-1:0] rng_data,
  output logic [WORD_W*NUM_WORDS-1:0] key_out,
  output logic                        key_valid
);
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int KEY_W     = WORD_W * NUM_WORDS;
  localparam int SPAN_BITS = IDX_W + 2;

  kb_event_t        ev;
  logic             key_hit;
  logic             key_wr;
  logic             ctrl_wr;
  logic             rng_load;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] exp_idx;
  logic             seq_err;
  logic             seq_restart;
  logic             seq_match;
  logic             seq_break;
  logic             seq_done;
  merge_mode_e      merge_mode;
  logic             mode_lock;
  logic [KEY_W-1:0] key_raw;

  assign key_hit  = (wr_addr >> SPAN_BITS) == '0;
  assign wr_idx   = wr_addr[SPAN_BITS-1:2];
  assign ev.rng_load = rng_valid;
  assign ev.key_wr   = wr_en && key_hit && !rng_valid;
  assign ev.ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign key_wr   = ev.key_wr;
  assign ctrl_wr  = ev.ctrl_wr;
  assign rng_load = ev.rng_load;

  kb_order_tracker #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (key_wr),
    .wr_idx      (wr_idx),
    .rng_load    (rng_load),
    .exp_idx     (exp_idx),
    .seq_err     (seq_err),
    .key_valid   (key_valid),
    .seq_restart (seq_restart),
    .seq_match   (seq_match),
    .seq_break   (seq_break),
    .seq_done    (seq_done)
  );

  kb_mode_ctrl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .mode_bit   (wr_data[MODE_POS]),
    .lock_bit   (wr_data[LOCK_POS]),
    .merge_mode (merge_mode),
    .mode_lock  (mode_lock)
  );

  kb_word_store #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .KEY_W(KEY_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (key_wr),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rng_load   (rng_load),
    .merge_mode (merge_mode),
    .rng_data   (rng_data),
    .key_raw    (key_raw)
  );

  assign key_out = key_valid ? key_raw : '0;
endmodule

// File: rtl/keybank_checker.sv
module keybank_checker
  import keybank_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int KEY_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_wr,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] exp_idx,
  input logic             rng_load,
  input logic             seq_break,
  input merge_mode_e      merge_mode,
  input logic             mode_lock,
  input logic             key_valid,
  input logic [KEY_W-1:0] key_out
);
  // R5: an invalid key never leaks onto the bus
  assert_zero_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> (key_out == '0));

  // R8: lock is sticky
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_lock |=> mode_lock);

  // R9: locked mode never moves
  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_lock |=> $stable(merge_mode));

  // R6: random load yields a valid key and restarts the tracker
  assert_rng_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rng_load |=> (key_valid && exp_idx == '0));

  // R3: an out-of-order write invalidates the key
  assert_break_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_break |=> !key_valid);

  // R4: word 0 restarts the sequence
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wr_idx == '0) |=> (!key_valid && exp_idx == IDX_W'(1)));
endmodule

bind ordered_key_bank keybank_checker #(.IDX_W(IDX_W), .KEY_W(KEY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_wr     (key_wr),
  .wr_idx     (wr_idx),
  .exp_idx    (exp_idx),
  .rng_load   (rng_load),
  .seq_break  (seq_break),
  .merge_mode (merge_mode),
  .mode_lock  (mode_lock),
  .key_valid  (key_valid),
  .key_out    (key_out)
);

// File: tb/tb_ordered_key_bank.sv
`timescale 1ns/1ps
module tb_ordered_key_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rng_valid = 1'b0;
  logic [255:0] rng_data = '0;
  logic [255:0] key_out;
  logic         key_valid;

  int n_checks = 0;
  int n_fails  = 0;

  logic [31:0] mw [8];
  int          m_exp;
  bit          m_err, m_valid, m_mode, m_lock;

  always #2.5 clk = ~clk;

  ordered_key_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rng_valid(rng_valid), .rng_data(rng_data),
    .key_out(key_out), .key_valid(key_valid)
  );

  function automatic logic [255:0] exp_key();
    logic [255:0] k = '0;
    if (m_valid)
      for (int i = 7; i >= 0; i--) k = {k[223:0], mw[i]};
    return k;
  endfunction

  function automatic logic [255:0] rand_wide();
    logic [255:0] r = '0;
    for (int i = 0; i < 8; i++) r = {r[223:0], $urandom()};
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mw[i] = '0;
    m_exp = 0; m_err = 0; m_valid = 0; m_mode = 0; m_lock = 0;
  endtask

  task automatic model_step(bit we, logic [7:0] a, logic [31:0] d, bit rv, logic [255:0] rd);
    bit kw = we && (a < 8'h20);
    int idx = int'(a[4:2]);
    if (rv) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] s = rd[i*32 +: 32];
        mw[i] = m_mode ? (mw[i] ^ s) : s;
      end
      m_valid = 1; m_err = 0; m_exp = 0;
    end else if (kw) begin
      mw[idx] = d;
      if (idx == 0) begin
        m_exp = 1; m_err = 0; m_valid = 0;
      end else if (!m_err && idx == m_exp) begin
        m_valid = (idx == 7);
        m_exp = (idx + 1) % 8;
      end else begin
        m_err = 1; m_valid = 0;
      end
    end
    if (we && a == 8'h48) begin
      if (!m_lock) m_mode = d[0];
      if (d[16]) m_lock = 1;
    end
  endtask

  task automatic check(string req);
    logic [255:0] ek = exp_key();
    n_checks++;
    if (key_valid !== m_valid || key_out !== ek) begin
      n_fails++;
      $display("FAIL %s: valid=%0b key=%h expected valid=%0b key=%h",
               req, key_valid, key_out, m_valid, ek);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic step(string req, bit we, logic [7:0] a, logic [31:0] d,
                      bit rv, logic [255:0] rd);
    wr_en = we; wr_addr = a; wr_data = d; rng_valid = rv; rng_data = rd;
    @(posedge clk);
    model_step(we, a, d, rv, rd);
    @(negedge clk);
    wr_en = 0; rng_valid = 0;
    check(req);
  endtask

  task automatic kwrite(string req, int idx, logic [31:0] d);
    step(req, 1, 8'(idx * 4), d, 0, '0);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rng_valid = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [255:0] r;
    void'($urandom(32'd20240611));
    do_reset();
    check("R1");

    // R2 / R5: ordered load
    for (int i = 0; i < 7; i++) kwrite("R5", i, 32'hA000_0000 + i);
    kwrite("R2", 7, 32'hA000_0007);

    // R4 restart, R3 break
    kwrite("R4", 0, 32'h1111_0000);
    kwrite("R2", 1, 32'h1111_0001);
    kwrite("R2", 2, 32'h1111_0002);
    kwrite("R3", 4, 32'h1111_0004);
    for (int i = 5; i < 8; i++) kwrite("R3", i, 32'h2222_0000 + i);
    kwrite("R3", 3, 32'h3333_3333);
    for (int i = 0; i < 8; i++) kwrite("R4", i, 32'h4444_0000 + i);
    // address low bits ignored (R2)
    step("R2", 1, 8'h03, 32'h5555_0000, 0, '0);
    step("R2", 1, 8'h06, 32'h5555_0001, 0, '0);

    // R6 overwrite load
    step("R6", 0, 8'h00, 0, 1, rand_wide());
    // R7 XOR load
    step("R8", 1, 8'h48, 32'h0000_0001, 0, '0);
    step("R7", 0, 8'h00, 0, 1, rand_wide());
    kwrite("R3", 2, 32'hDEAD_BEEF);
    step("R7", 0, 8'h00, 0, 1, rand_wide());

    // R10 simultaneous load and write
    step("R10", 1, 8'h00, 32'hFFFF_FFFF, 1, rand_wide());
    kwrite("R10", 5, 32'h0BAD_0BAD);

    // R11 unmapped writes
    step("R6", 0, 8'h00, 0, 1, rand_wide());
    step("R11", 1, 8'h20, 32'hFFFF_FFFF, 0, '0);
    step("R11", 1, 8'h44, 32'hFFFF_FFFF, 0, '0);
    step("R11", 1, 8'h4C, 32'hFFFF_FFFF, 0, '0);
    step("R11", 1, 8'hFF, 32'hFFFF_FFFF, 0, '0);
    step("R11", 0, 8'h00, 0, 1, 256'h0);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom() % 10);
      if (op < 6) begin
        int idx = ($urandom() % 4 != 0) ? m_exp : int'($urandom() % 8);
        step("R3", 1, 8'(idx * 4) | 8'($urandom() % 4), $urandom(), 0, '0);
      end else if (op == 6) begin
        logic [31:0] d = $urandom() & 32'hFFFE_FFFF;
        if ($urandom() % 8 == 0) d[16] = 1'b1;
        step("R9", 1, 8'h48, d, 0, '0);
      end else if (op == 7) begin
        step("R7", $urandom() % 2 == 0, 8'(($urandom() % 8) * 4), $urandom(), 1, rand_wide());
      end else if (op == 8) begin
        logic [7:0] a = 8'h20 + 8'($urandom() % 8'hE0);
        if (a == 8'h48) a = 8'h49;
        step("R11", 1, a, $urandom(), 0, '0);
      end else begin
        step("R5", 0, 8'h00, 0, 0, '0);
      end
    end

    // R8 / R9 directed after a fresh reset
    do_reset();
    step("R9", 1, 8'h48, 32'h0001_0001, 0, '0);
    step("R8", 1, 8'h48, 32'h0000_0000, 0, '0);
    r = rand_wide();
    step("R6", 0, 8'h00, 0, 1, r);
    step("R9", 0, 8'h00, 0, 1, r);
    n_checks++;
    if (key_out !== 256'h0 || key_valid !== 1'b1) begin
      n_fails++;
      $display("FAIL R9: key=%h expected all zero (xor of equal loads)", key_out);
    end
    do_reset();
    check("R1");
    r = rand_wide();
    step("R1", 0, 8'h00, 0, 1, r);
    step("R1", 0, 8'h00, 0, 1, r);
    n_checks++;
    if (key_out !== r) begin
      n_fails++;
      $display("FAIL R1: key=%h expected=%h (reset mode overwrite)", key_out, r);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule